// File: doc/BRIEF.md
# Pixel Port Unpacker with Legacy Pass-Through

This block sits between a 32-bit packed pixel port and a colour lookup stage. It turns each latched word into a stream of per-dot pixel indices. A configuration register picks the active bus width (8, 16 or 32 bits) and the pixel depth (4 or 8 bits). The bus rate does not change: a wider setting only packs more pixels into each latched group. A separate mode sends 8-bit pixels from a legacy bus straight through, paced by its own enable. Selecting that mode returns the clock-select, general-control and read-mask registers to their defaults. The block emits one masked index per dot enable. It flags the first pixel of every group, so downstream logic can count shift-clock loads.

The block has four control states. `ST_PASS` forwards legacy pixels. `ST_START` waits at a group boundary for a dot enable to latch a new word. `ST_UNPACK` shifts out the remaining fields of a latched word. `ST_SPLIT` waits while a split-transfer gap is pending. The transitions are:
- reset enters `ST_PASS`.
- `ST_PASS` goes to `ST_START` once the effective mode is not pass-through.
- `ST_START` goes to `ST_PASS` when the effective mode is pass-through.
- `ST_START` goes to `ST_UNPACK` on a latch when the group holds more than one pixel.
- `ST_START` goes to `ST_SPLIT` on a dot enable while the split hold is active.
- `ST_UNPACK` goes to `ST_START` after the last field, or at once when blank is asserted.
- `ST_SPLIT` goes to `ST_START` when the hold drops or blank is asserted, and to `ST_PASS` if pass-through was selected.

Top module: `pix_port_mux`

## Requirements
- R1: After reset, the mode is 0 (pass-through), `clk_sel` is 0, `gen_ctl` is 0x00, the read mask is 0xFF, and `pix_valid` and `grp_load` are low.
- R2: Mode codes set the pixels per group and the field width. Code 1 is 8-bit bus at 4 bpp (2 pixels). Code 2 is 16-bit bus at 4 bpp (4 pixels). Code 3 is 32-bit bus at 4 bpp (8 pixels). Code 4 is 8-bit bus at 8 bpp (1 pixel). Code 5 is 16-bit bus at 8 bpp (2 pixels). Code 6 is 32-bit bus at 8 bpp (4 pixels). Code 7 behaves as code 6. Port bits beyond the fields in use are ignored.
- R3: Within a group, pixel fields leave least-significant first, one per dot enable. `pix_valid` is high for exactly the cycle after each accepted enable, and `pix_idx` holds that pixel.
- R4: Every emitted index is ANDed with the read mask current at emission. In 4-bit modes, bits 7:4 of `pix_idx` are 0.
- R5: In mode 0, each `clk0_en` with blank low emits `legacy_pix` AND mask, while `dot_en` and `pix_port` are ignored. In other modes, `clk0_en` is ignored.
- R6: A mode write of 0 sets `clk_sel` to 0, `gen_ctl` to 0x00 and the mask to 0xFF on the same edge, overriding same-cycle writes to those registers.
- R7: While `blank` is high, no pixel is emitted and the group position returns to the start. The first dot enable after blank latches a fresh word.
- R8: When `gen_ctl` bit 2 is 1 and `split_flag` is high at a group boundary, no word is latched and nothing is emitted until the flag drops. With bit 2 at 0, the flag has no effect.
- R9: A mode write takes effect only at a group boundary. Fields of a partly emitted group keep the old width, and `mode_active` reports the mode in force.
- R10: `grp_load` pulses together with the first pixel of every group latched from `pix_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_we | input | 1 | Write strobe for the mode register |
| cfg_mode | input | 3 | Mode code to write |
| cfg_clksel_we | input | 1 | Write strobe for clock select |
| cfg_clksel | input | 4 | Clock-select value to write |
| cfg_gctl_we | input | 1 | Write strobe for general control |
| cfg_gctl | input | 8 | General-control value (bit 2 enables split hold) |
| cfg_mask_we | input | 1 | Write strobe for the read mask |
| cfg_mask | input | 8 | Read-mask value to write |
| dot_en | input | 1 | Dot-rate enable for packed modes |
| clk0_en | input | 1 | Pixel enable for pass-through mode |
| blank | input | 1 | Active-high blanking |
| split_flag | input | 1 | Split-transfer gap request |
| pix_port | input | 32 | Packed pixel word |
| legacy_pix | input | 8 | Pass-through pixel bus |
| pix_idx | output | 8 | Masked pixel index |
| pix_valid | output | 1 | Index strobe |
| grp_load | output | 1 | First pixel of a freshly latched group |
| clk_sel | output | 4 | Clock-select register |
| gen_ctl | output | 8 | General-control register |
| mode_active | output | 3 | Mode in force |

## Verification
Pixel outputs are registered, so each index, its valid strobe and `grp_load` are due one clock after the edge that accepts the enable. The bench drives on the falling edge and compares at the next falling edge. Register writes, including the forced defaults, are visible one edge after the strobe. `mode_active` follows a boundary-time mode write one further edge later, so the bench leaves idle cycles before reading it. Idle cycles between dots are also checked for a low `pix_valid`, which catches extra or misplaced strobes.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    localparam int PORT_W     = 32;
    localparam int IDX_W      = 8;
    localparam int NARROW_W   = 4;
    localparam int MODE_W     = 3;
    localparam int CLKSEL_W   = 4;
    localparam int SLOT_W     = $clog2(PORT_W / NARROW_W);
    localparam int SPLIT_BIT  = 2;

    localparam logic [MODE_W-1:0]   MODE_PASS  = '0;
    localparam logic [CLKSEL_W-1:0] CLKSEL_DEF = '0;
    localparam logic [IDX_W-1:0]    GCTL_DEF   = '0;
    localparam logic [IDX_W-1:0]    MASK_DEF   = '1;

    typedef enum logic [1:0] {
        ST_PASS,
        ST_START,
        ST_UNPACK,
        ST_SPLIT
    } ppm_state_e;

    typedef struct packed {
        logic              pass;
        logic              wide;
        logic [SLOT_W-1:0] last_slot;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        mode_cfg_t c;
        c.pass = 1'b0;
        c.wide = 1'b1;
        c.last_slot = '0;
        case (m)
            3'd0: c.pass = 1'b1;
            3'd1: begin c.wide = 1'b0; c.last_slot = SLOT_W'(1); end
            3'd2: begin c.wide = 1'b0; c.last_slot = SLOT_W'(3); end
            3'd3: begin c.wide = 1'b0; c.last_slot = SLOT_W'(7); end
            3'd4: c.last_slot = SLOT_W'(0);
            3'd5: c.last_slot = SLOT_W'(1);
            default: c.last_slot = SLOT_W'(3);
        endcase
        return c;
    endfunction
endpackage

// File: rtl/ppm_cfg_regs.sv
module ppm_cfg_regs
    import ppm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_we,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic                clksel_we,
    input  logic [CLKSEL_W-1:0] clksel_in,
    input  logic                gctl_we,
    input  logic [IDX_W-1:0]    gctl_in,
    input  logic                mask_we,
    input  logic [IDX_W-1:0]    mask_in,
    input  logic                at_boundary,
    output logic [MODE_W-1:0]   mode_eff,
    output logic [MODE_W-1:0]   mode_act,
    output logic [CLKSEL_W-1:0] clk_sel,
    output logic [IDX_W-1:0]    gen_ctl,
    output logic [IDX_W-1:0]    rd_mask
);
    logic [MODE_W-1:0]   pend_q, act_q;
    logic [CLKSEL_W-1:0] clksel_q;
    logic [IDX_W-1:0]    gctl_q, mask_q;
    logic                force_def;

    assign force_def = mode_we && (mode_in == MODE_PASS);
    assign mode_eff  = at_boundary ? pend_q : act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= MODE_PASS;
            act_q    <= MODE_PASS;
            clksel_q <= CLKSEL_DEF;
            gctl_q   <= GCTL_DEF;
            mask_q   <= MASK_DEF;
        end else begin
            act_q <= mode_eff;
            if (mode_we) pend_q <= mode_in;
            if (force_def) begin
                clksel_q <= CLKSEL_DEF;
                gctl_q   <= GCTL_DEF;
                mask_q   <= MASK_DEF;
            end else begin
                if (clksel_we) clksel_q <= clksel_in;
                if (gctl_we)   gctl_q   <= gctl_in;
                if (mask_we)   mask_q   <= mask_in;
            end
        end
    end

    assign mode_act = act_q;
    assign clk_sel  = clksel_q;
    assign gen_ctl  = gctl_q;
    assign rd_mask  = mask_q;

    assert_force_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_def |=> (clksel_q == CLKSEL_DEF && gctl_q == GCTL_DEF && mask_q == MASK_DEF));

    assert_mode_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |=> (act_q == $past(act_q)));
endmodule

// File: rtl/ppm_ctrl_fsm.sv
module ppm_ctrl_fsm
    import ppm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mode_cfg_t mcfg,
    input  logic      dot_en,
    input  logic      clk0_en,
    input  logic      blank,
    input  logic      split_hold,
    output logic      do_load,
    output logic      do_shift,
    output logic      do_pass,
    output logic      at_boundary
);
    ppm_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              dot_ok;

    assign dot_ok = dot_en && !blank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (blank || state_d != ST_UNPACK) slot_q <= '0;
            else if (do_load)                  slot_q <= SLOT_W'(1);
            else if (do_shift)                 slot_q <= slot_q + SLOT_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: begin
                if (!mcfg.pass) state_d = ST_START;
            end
            ST_START: begin
                if (mcfg.pass)                             state_d = ST_PASS;
                else if (dot_ok && split_hold)             state_d = ST_SPLIT;
                else if (dot_ok && mcfg.last_slot != '0)   state_d = ST_UNPACK;
            end
            ST_UNPACK: begin
                if (blank)                                 state_d = ST_START;
                else if (dot_en && slot_q == mcfg.last_slot) state_d = ST_START;
            end
            ST_SPLIT: begin
                if (mcfg.pass)                     state_d = ST_PASS;
                else if (blank || !split_hold)     state_d = ST_START;
            end
            default: state_d = ST_START;
        endcase
    end

    always_comb begin
        do_load     = 1'b0;
        do_shift    = 1'b0;
        do_pass     = 1'b0;
        at_boundary = 1'b1;
        unique case (state_q)
            ST_PASS:   do_pass  = mcfg.pass && clk0_en && !blank;
            ST_START:  do_load  = !mcfg.pass && dot_ok && !split_hold;
            ST_UNPACK: begin
                do_shift    = dot_ok;
                at_boundary = 1'b0;
            end
            ST_SPLIT:  do_load  = 1'b0;
            default:   do_load  = 1'b0;
        endcase
    end

    assert_single_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_load, do_shift, do_pass}));

    assert_blank_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (slot_q == '0));
endmodule

// File: rtl/ppm_unpack.sv
module ppm_unpack
    import ppm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic              do_shift,
    input  logic              do_pass,
    input  logic              wide,
    input  logic [PORT_W-1:0] port_word,
    input  logic [IDX_W-1:0]  legacy_word,
    input  logic [IDX_W-1:0]  mask,
    output logic [IDX_W-1:0]  idx,
    output logic              valid,
    output logic              first
);
    logic [PORT_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              valid_q, first_q, narrow_q;

    function automatic logic [IDX_W-1:0] pick(input logic [PORT_W-1:0] w, input logic wd);
        return wd ? w[IDX_W-1:0] : {{(IDX_W-NARROW_W){1'b0}}, w[NARROW_W-1:0]};
    endfunction

    function automatic logic [PORT_W-1:0] advance(input logic [PORT_W-1:0] w, input logic wd);
        return wd ? (w >> IDX_W) : (w >> NARROW_W);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            idx_q    <= '0;
            valid_q  <= 1'b0;
            first_q  <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            valid_q  <= do_load || do_shift || do_pass;
            first_q  <= do_load;
            narrow_q <= (do_load || do_shift) && !wide;
            if (do_load) begin
                idx_q   <= pick(port_word, wide) & mask;
                shreg_q <= advance(port_word, wide);
            end else if (do_shift) begin
                idx_q   <= pick(shreg_q, wide) & mask;
                shreg_q <= advance(shreg_q, wide);
            end else if (do_pass) begin
                idx_q   <= legacy_word & mask;
            end
        end
    end

    assign idx   = idx_q;
    assign valid = valid_q;
    assign first = first_q;

    assert_load_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> valid_q);

    assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && narrow_q) |-> (idx_q[IDX_W-1:NARROW_W] == '0));
endmodule

// File: rtl/pix_port_mux.sv
module pix_port_mux
    import ppm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_mode_we,
    input  logic [MODE_W-1:0]   cfg_mode,
    input  logic                cfg_clksel_we,
    input  logic [CLKSEL_W-1:0] cfg_clksel,
    input  logic                cfg_gctl_we,
    input  logic [IDX_W-1:0]    cfg_gctl,
    input  logic                cfg_mask_we,
    input  logic [IDX_W-1:0]    cfg_mask,
    input  logic                dot_en,
    input  logic                clk0_en,
    input  logic                blank,
    input  logic                split_flag,
    input  logic [PORT_W-1:0]   pix_port,
    input  logic [IDX_W-1:0]    legacy_pix,
    output logic [IDX_W-1:0]    pix_idx,
    output logic                pix_valid,
    output logic                grp_load,
    output logic [CLKSEL_W-1:0] clk_sel,
    output logic [IDX_W-1:0]    gen_ctl,
    output logic [MODE_W-1:0]   mode_active
);
    logic [MODE_W-1:0] mode_eff;
    logic [IDX_W-1:0]  rd_mask;
    mode_cfg_t         mcfg;
    logic              at_boundary, split_hold;
    logic              do_load, do_shift, do_pass;

    assign mcfg       = decode_mode(mode_eff);
    assign split_hold = gen_ctl[SPLIT_BIT] && split_flag;

    ppm_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (cfg_mode_we),
        .mode_in    (cfg_mode),
        .clksel_we  (cfg_clksel_we),
        .clksel_in  (cfg_clksel),
        .gctl_we    (cfg_gctl_we),
        .gctl_in    (cfg_gctl),
        .mask_we    (cfg_mask_we),
        .mask_in    (cfg_mask),
        .at_boundary(at_boundary),
        .mode_eff   (mode_eff),
        .mode_act   (mode_active),
        .clk_sel    (clk_sel),
        .gen_ctl    (gen_ctl),
        .rd_mask    (rd_mask)
    );

    ppm_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mcfg       (mcfg),
        .dot_en     (dot_en),
        .clk0_en    (clk0_en),
        .blank      (blank),
        .split_hold (split_hold),
        .do_load    (do_load),
        .do_shift   (do_shift),
        .do_pass    (do_pass),
        .at_boundary(at_boundary)
    );

    ppm_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_load    (do_load),
        .do_shift   (do_shift),
        .do_pass    (do_pass),
        .wide       (mcfg.wide),
        .port_word  (pix_port),
        .legacy_word(legacy_pix),
        .mask       (rd_mask),
        .idx        (pix_idx),
        .valid      (pix_valid),
        .first      (grp_load)
    );

    assert_valid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(dot_en || clk0_en));

    assert_blank_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !pix_valid);

    assert_split_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_load |-> !$past(gen_ctl[SPLIT_BIT] && split_flag));
endmodule

// File: tb/pix_port_mux_tb.sv
module pix_port_mux_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_mode_we, cfg_clksel_we, cfg_gctl_we, cfg_mask_we;
    logic [2:0]  cfg_mode;
    logic [3:0]  cfg_clksel;
    logic [7:0]  cfg_gctl, cfg_mask;
    logic        dot_en, clk0_en, blank, split_flag;
    logic [31:0] pix_port;
    logic [7:0]  legacy_pix;
    logic [7:0]  pix_idx;
    logic        pix_valid, grp_load;
    logic [3:0]  clk_sel;
    logic [7:0]  gen_ctl;
    logic [2:0]  mode_active;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] cur_mask = 8'hFF;

    always #2.5 clk = ~clk;

    pix_port_mux u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode),
        .cfg_clksel_we(cfg_clksel_we), .cfg_clksel(cfg_clksel),
        .cfg_gctl_we(cfg_gctl_we), .cfg_gctl(cfg_gctl),
        .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
        .dot_en(dot_en), .clk0_en(clk0_en), .blank(blank), .split_flag(split_flag),
        .pix_port(pix_port), .legacy_pix(legacy_pix),
        .pix_idx(pix_idx), .pix_valid(pix_valid), .grp_load(grp_load),
        .clk_sel(clk_sel), .gen_ctl(gen_ctl), .mode_active(mode_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ppg_of(input int m);
        case (m)
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 1;
            5: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] exp_field(input int m, input logic [31:0] w,
                                             input int s, input logic [7:0] k);
        logic [7:0] f;
        if (m >= 4) f = w[8*s +: 8];
        else        f = {4'h0, w[4*s +: 4]};
        return f & k;
    endfunction

    task automatic cfg_write(input bit wm, input logic [2:0] m, input bit wc, input logic [3:0] c,
                             input bit wg, input logic [7:0] g, input bit wk, input logic [7:0] k);
        cfg_mode_we = wm; cfg_mode = m;
        cfg_clksel_we = wc; cfg_clksel = c;
        cfg_gctl_we = wg; cfg_gctl = g;
        cfg_mask_we = wk; cfg_mask = k;
        @(negedge clk);
        cfg_mode_we = 0; cfg_clksel_we = 0; cfg_gctl_we = 0; cfg_mask_we = 0;
        if (wm && m == 3'd0) cur_mask = 8'hFF;
        else if (wk) cur_mask = k;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            dot_en = 0; clk0_en = 0;
            @(negedge clk);
            chk(req, pix_valid, 0);
        end
    endtask

    task automatic dot(input logic [31:0] w, input logic [7:0] e, input bit first, input string req);
        pix_port = w; dot_en = 1;
        @(negedge clk);
        dot_en = 0;
        pix_port = $urandom;
        chk(req, pix_valid, 1);
        chk(req, pix_idx, e);
        chk("R10", grp_load, first);
    endtask

    task automatic group_part(input int m, input logic [31:0] w, input int from, input int upto,
                              input string req);
        for (int s = from; s < upto; s++) begin
            idle($urandom % 3, "R3 idle");
            dot(w, exp_field(m, w, s, cur_mask), s == 0, req);
        end
    endtask

    task automatic set_mode(input int m);
        cfg_write(1, 3'(m), 0, 0, 0, 0, 0, 0);
        idle(2, "R9 settle");
        chk("R9 mode_active", mode_active, m);
    endtask

    task automatic pass_emit(input logic [7:0] v, input string req);
        legacy_pix = v; clk0_en = 1;
        @(negedge clk);
        clk0_en = 0;
        chk(req, pix_valid, 1);
        chk(req, pix_idx, v & cur_mask);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w, w2;
        void'($urandom(32'h5EED_1234));
        rst_n = 0;
        cfg_mode_we = 0; cfg_clksel_we = 0; cfg_gctl_we = 0; cfg_mask_we = 0;
        cfg_mode = 0; cfg_clksel = 0; cfg_gctl = 0; cfg_mask = 0;
        dot_en = 0; clk0_en = 0; blank = 0; split_flag = 0;
        pix_port = 0; legacy_pix = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        chk("R1 mode", mode_active, 0);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 gen_ctl", gen_ctl, 0);
        chk("R1 valid", pix_valid, 0);
        chk("R1 grp_load", grp_load, 0);
        pass_emit(8'hA5, "R1 mask default");

        // R5 pass-through: dot_en ignored, clk0_en drives output
        pix_port = 32'hFFFF_FFFF; dot_en = 1;
        @(negedge clk);
        dot_en = 0;
        chk("R5 dot ignored", pix_valid, 0);
        cfg_write(0, 0, 0, 0, 0, 0, 1, 8'h3C);
        pass_emit(8'hF7, "R5 pass masked");
        pass_emit(8'h81, "R5 pass masked");

        // R2/R3/R4 each packed mode
        for (int m = 1; m <= 7; m++) begin
            set_mode(m);
            cfg_write(0, 0, 0, 0, 0, 0, 1, (m % 2) ? 8'hFF : 8'($urandom));
            for (int g = 0; g < 3; g++) begin
                w = $urandom;
                group_part(m, w, 0, ppg_of(m), "R2 R3 R4 unpack");
            end
            legacy_pix = 8'h55; clk0_en = 1;
            @(negedge clk);
            clk0_en = 0;
            chk("R5 clk0_en ignored", pix_valid, 0);
        end

        // R9 mode change mid-group waits for the boundary
        set_mode(3);
        cfg_write(0, 0, 0, 0, 0, 0, 1, 8'hFF);
        w = 32'h8765_4321;
        group_part(3, w, 0, 2, "R9 old group");
        cfg_write(1, 3'd6, 0, 0, 0, 0, 0, 0);
        idle(1, "R9");
        chk("R9 still old", mode_active, 3);
        group_part(3, w, 2, 8, "R9 old width kept");
        idle(2, "R9");
        chk("R9 new mode", mode_active, 6);
        w = 32'hDEAD_BEEF;
        group_part(6, w, 0, 4, "R9 new width");

        // R7 blank mid-group restarts position
        set_mode(3);
        w = 32'h1357_9BDF;
        group_part(3, w, 0, 3, "R7 pre-blank");
        blank = 1; dot_en = 1; pix_port = w;
        @(negedge clk);
        chk("R7 blank no valid", pix_valid, 0);
        blank = 0; dot_en = 0;
        idle(1, "R7");
        w2 = 32'h2468_ACE0;
        group_part(3, w2, 0, 8, "R7 fresh group");

        // R8 split hold at a boundary
        cfg_write(0, 0, 0, 0, 1, 8'h04, 0, 0);
        chk("R8 gen_ctl", gen_ctl, 8'h04);
        split_flag = 1;
        for (int i = 0; i < 3; i++) begin
            dot_en = 1; pix_port = 32'hFFFF_FFFF;
            @(negedge clk);
            dot_en = 0;
            chk("R8 stalled", pix_valid, 0);
            chk("R8 no load", grp_load, 0);
        end
        split_flag = 0;
        idle(2, "R8");
        w = 32'hCAFE_F00D;
        group_part(3, w, 0, 1, "R8 resumes");
        split_flag = 1;
        group_part(3, w, 1, 8, "R8 mid-group flag ignored");
        split_flag = 0;
        cfg_write(0, 0, 0, 0, 1, 8'h00, 0, 0);
        split_flag = 1;
        w = 32'h0BAD_CAFE;
        group_part(3, w, 0, 8, "R8 disabled flag ignored");
        split_flag = 0;

        // R6 entering mode 0 forces defaults over same-cycle writes
        cfg_write(0, 0, 1, 4'h9, 1, 8'h04, 1, 8'h3C);
        chk("R6 pre clk_sel", clk_sel, 4'h9);
        cfg_write(1, 3'd0, 1, 4'h7, 1, 8'h24, 1, 8'h11);
        chk("R6 clk_sel", clk_sel, 0);
        chk("R6 gen_ctl", gen_ctl, 0);
        idle(2, "R6");
        chk("R6 mode", mode_active, 0);
        pass_emit(8'hAA, "R6 mask default");

        // random mix
        for (int g = 0; g < 40; g++) begin
            int m;
            m = 1 + ($urandom % 7);
            set_mode(m);
            cfg_write(0, 0, 0, 0, 0, 0, 1, 8'($urandom));
            if ($urandom % 4 == 0) begin
                blank = 1; dot_en = 1;
                @(negedge clk);
                blank = 0; dot_en = 0;
                chk("R7 random blank", pix_valid, 0);
            end
            w = $urandom;
            group_part(m, w, 0, ppg_of(m), "R2 R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule